// File: doc/BRIEF.md
# Serial EEPROM Image Programmer

This block rewrites a complete configuration image into a three-wire serial EEPROM and then proves the write by reading every word back. A single start pulse begins the sequence. The block first probes the device to learn whether it uses 6-bit or 8-bit word addresses, which sets the image to 64 or 256 sixteen-bit words. It then builds the image in a local register array from the station address and a fixed default pattern, and closes the image with a checksum word.

Each word is programmed under a write-enable/write-disable bracket with ready polls between the steps. The block then reads back the whole image and compares it with the local copy. The block does not produce bit-level serial timing. It hands each operation to a serial master as a right-aligned frame with a bit count, or as a ready-poll request, and waits for that master's completion pulse and captured response. The result (done, pass, first failing address) stays on the outputs until the next start.

Top module: `eeprom_image_prog`

## Requirements
- R1: After start, the first operation is a 28-bit frame of value 0x6000000 (a read command with an 8-bit zero address and 16 data clocks). If bits 27..17 of its response are all ones, the device is taken as 8-bit addressed (256 words). Otherwise it is taken as 6-bit addressed (64 words). Exactly that many words are written.
- R2: With A the address width, frames are right-aligned in op_bits and sent MSB first. A write is {3'b101, addr, data} of A+19 bits. A read is {3'b110, addr, 16'h0} of A+19 bits. Write-enable is {3'b100, 2'b11, zeros} of A+3 bits. Write-disable is {3'b100, zeros} of A+3 bits. A ready poll has op_poll=1 and op_len=0.
- R3: Image word i for i<3 is station_addr[16i+15:16i]. Word 10 is 0x40C0, and words 11 and 12 are 0x0000. Every other word below the last is 0xFFFF.
- R4: The last word equals 0xBABA minus the 16-bit wrapping sum of all earlier words, so all words of the image sum to 0xBABA.
- R5: Each word is programmed by this sequence: poll, enable, write, poll, disable, poll.
- R6: Writes go in ascending address order from 0. Reads start only after every write and also go in ascending order from 0.
- R7: At the first read-back mismatch, the block stops, raises done with pass=0, and reports that address on fail_addr. No further reads are issued.
- R8: If every word matches, the block raises done with pass=1.
- R9: After reset, done and pass are 0. Done, pass and fail_addr hold until the next start, which clears done. A start while a run is in progress is ignored.
- R10: op_req is a one-cycle pulse. No new request is raised until op_done answers the previous one, and no request is raised while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a program-and-verify run (honoured when idle or done) |
| station_addr | input | 48 | Station address, byte k at bits 8k+7..8k |
| op_req | output | 1 | One-cycle request to the serial master |
| op_poll | output | 1 | Request is a ready poll rather than a frame |
| op_bits | output | 28 | Right-aligned frame to shift out |
| op_len | output | 5 | Number of frame bits |
| op_done | input | 1 | Master completion pulse |
| op_rdata | input | 28 | Bits captured during the frame, right-aligned |
| done | output | 1 | Run finished |
| pass | output | 1 | All words read back correctly |
| fail_addr | output | 8 | Address of the first mismatching word |

## Verification
The assertions rely on the serial master giving exactly one op_done for each op_req, and never before the request. The handshake and request-spacing properties depend on that. The bench's master model honours this contract: it holds each request as pending for a fixed latency of one cycle for frames and three cycles for polls, and it counts any request that arrives while one is still pending as a protocol error. The model answers the probe frame to imitate a 6-bit or an 8-bit device. It corrupts read-back only at chosen addresses, so the first-failure address can be predicted arithmetically.

// File: rtl/eeprom_image_prog.sv
module eeprom_image_prog #(
  parameter int NARROW_AW = 6,
  parameter int WIDE_AW = 8,
  parameter logic [15:0] SUM_TARGET = 16'hBABA,
  localparam int DEPTH = 1 << WIDE_AW,
  localparam int FRAME_W = WIDE_AW + 20,
  localparam int LEN_W = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [47:0]        station_addr,
  output logic               op_req,
  output logic               op_poll,
  output logic [FRAME_W-1:0] op_bits,
  output logic [LEN_W-1:0]   op_len,
  input  logic               op_done,
  input  logic [FRAME_W-1:0] op_rdata,
  output logic               done,
  output logic               pass,
  output logic [WIDE_AW-1:0] fail_addr
);

  typedef enum logic [3:0] {
    S_IDLE, S_PROBE, S_FILL, S_POLL_A, S_EWEN, S_WR,
    S_POLL_B, S_EWDS, S_POLL_C, S_RD, S_DONE
  } st_t;

  st_t                st;
  logic               wait_q, wide_q, pass_q;
  logic [WIDE_AW-1:0] idx_q, fail_q;
  logic [15:0]        sum_q, dflt;
  logic [47:0]        sta_q;
  logic [15:0]        img [DEPTH];

  wire [WIDE_AW-1:0] last_idx = wide_q ? {WIDE_AW{1'b1}} : WIDE_AW'((1 << NARROW_AW) - 1);
  wire [LEN_W-1:0]   aw = wide_q ? LEN_W'(WIDE_AW) : LEN_W'(NARROW_AW);
  wire               is_last = (idx_q == last_idx);
  wire [15:0]        cur_word = img[idx_q];

  wire [FRAME_W-1:0] addr_f  = FRAME_W'(idx_q) << 16;
  wire [FRAME_W-1:0] probe_f = FRAME_W'(3'b110) << (WIDE_AW + 16);
  wire [FRAME_W-1:0] wr_f    = (FRAME_W'(3'b101) << (aw + LEN_W'(16))) | addr_f | FRAME_W'(cur_word);
  wire [FRAME_W-1:0] rd_f    = (FRAME_W'(3'b110) << (aw + LEN_W'(16))) | addr_f;
  wire [FRAME_W-1:0] dis_f   = FRAME_W'(3'b100) << aw;
  wire [FRAME_W-1:0] en_f    = dis_f | (FRAME_W'(2'b11) << (aw - LEN_W'(2)));
  wire               rd_bad  = (op_rdata & FRAME_W'(16'hFFFF)) != FRAME_W'(cur_word);

  always_comb begin
    if (idx_q < WIDE_AW'(3))                         dflt = sta_q[{idx_q[1:0], 4'b0000} +: 16];
    else if (idx_q == WIDE_AW'(10))                  dflt = 16'h40C0;
    else if (idx_q == WIDE_AW'(11) || idx_q == WIDE_AW'(12)) dflt = 16'h0000;
    else                                             dflt = 16'hFFFF;
  end

  assign op_poll = (st == S_POLL_A) || (st == S_POLL_B) || (st == S_POLL_C);
  assign op_req  = !wait_q && (op_poll || st == S_PROBE || st == S_EWEN ||
                               st == S_WR || st == S_EWDS || st == S_RD);

  always_comb begin
    op_bits = '0;
    op_len  = '0;
    case (st)
      S_PROBE: begin op_bits = probe_f; op_len = LEN_W'(FRAME_W); end
      S_EWEN:  begin op_bits = en_f;    op_len = aw + LEN_W'(3); end
      S_WR:    begin op_bits = wr_f;    op_len = aw + LEN_W'(19); end
      S_EWDS:  begin op_bits = dis_f;   op_len = aw + LEN_W'(3); end
      S_RD:    begin op_bits = rd_f;    op_len = aw + LEN_W'(19); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      wait_q <= 1'b0;
      wide_q <= 1'b0;
      pass_q <= 1'b0;
      idx_q  <= '0;
      fail_q <= '0;
      sum_q  <= '0;
      sta_q  <= '0;
    end else begin
      if (op_req) wait_q <= 1'b1;
      case (st)
        S_IDLE, S_DONE:
          if (start) begin
            st     <= S_PROBE;
            pass_q <= 1'b0;
            fail_q <= '0;
            sta_q  <= station_addr;
          end
        S_PROBE:
          if (op_done) begin
            wait_q <= 1'b0;
            wide_q <= &op_rdata[FRAME_W-1 -: WIDE_AW+3];
            idx_q  <= '0;
            sum_q  <= '0;
            st     <= S_FILL;
          end
        S_FILL:
          if (is_last) begin
            idx_q <= '0;
            st    <= S_POLL_A;
          end else begin
            sum_q <= sum_q + dflt;
            idx_q <= idx_q + 1'b1;
          end
        S_POLL_A: if (op_done) begin wait_q <= 1'b0; st <= S_EWEN;   end
        S_EWEN:   if (op_done) begin wait_q <= 1'b0; st <= S_WR;     end
        S_WR:     if (op_done) begin wait_q <= 1'b0; st <= S_POLL_B; end
        S_POLL_B: if (op_done) begin wait_q <= 1'b0; st <= S_EWDS;   end
        S_EWDS:   if (op_done) begin wait_q <= 1'b0; st <= S_POLL_C; end
        S_POLL_C:
          if (op_done) begin
            wait_q <= 1'b0;
            if (is_last) begin
              idx_q <= '0;
              st    <= S_RD;
            end else begin
              idx_q <= idx_q + 1'b1;
              st    <= S_POLL_A;
            end
          end
        S_RD:
          if (op_done) begin
            wait_q <= 1'b0;
            if (rd_bad) begin
              fail_q <= idx_q;
              st     <= S_DONE;
            end else if (is_last) begin
              pass_q <= 1'b1;
              st     <= S_DONE;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (st == S_FILL) img[idx_q] <= is_last ? SUM_TARGET - sum_q : dflt;

  assign done      = (st == S_DONE);
  assign pass      = pass_q;
  assign fail_addr = fail_q;

endmodule

module eeprom_image_prog_chk #(
  parameter int NARROW_AW = 6,
  parameter int WIDE_AW = 8,
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             op_req,
  input logic             op_poll,
  input logic [LEN_W-1:0] op_len,
  input logic             op_done,
  input logic             done,
  input logic             pass,
  input logic [WIDE_AW-1:0] fail_addr
);
  logic outst;
  always_ff @(posedge clk)
    if (!rst_n) outst <= 1'b0;
    else if (op_req) outst <= 1'b1;
    else if (op_done) outst <= 1'b0;

  a_r10_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    op_req |=> !op_req);
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    op_req |-> !outst);
  a_r10_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !op_req);
  a_r2_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req && !op_poll) |-> (op_len == LEN_W'(NARROW_AW + 3) || op_len == LEN_W'(WIDE_AW + 3) ||
                              op_len == LEN_W'(NARROW_AW + 19) || op_len == LEN_W'(WIDE_AW + 19) ||
                              op_len == LEN_W'(WIDE_AW + 20)));
  a_r2_poll_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req && op_poll) |-> op_len == '0);
  a_r8_pass_done: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pass) && $stable(fail_addr)));
endmodule

bind eeprom_image_prog eeprom_image_prog_chk #(
  .NARROW_AW(NARROW_AW), .WIDE_AW(WIDE_AW), .LEN_W(LEN_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .op_req(op_req), .op_poll(op_poll),
  .op_len(op_len), .op_done(op_done), .done(done), .pass(pass), .fail_addr(fail_addr)
);

// File: tb/eeprom_image_prog_tb_top.sv
module eeprom_image_prog_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [47:0] sta = '0;
  logic        op_req, op_poll, done, pass;
  logic        op_done = 1'b0;
  logic [27:0] op_bits, op_rdata = '0;
  logic [4:0]  op_len;
  logic [7:0]  fail_addr;

  always #10 clk = ~clk;

  eeprom_image_prog dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .station_addr(sta),
    .op_req(op_req), .op_poll(op_poll), .op_bits(op_bits), .op_len(op_len),
    .op_done(op_done), .op_rdata(op_rdata), .done(done), .pass(pass), .fail_addr(fail_addr)
  );

  int checks = 0, errors = 0;
  logic [15:0] mem [256];
  int m_aw = 6, fault_a = -1, fault_b = -1;
  int n_probe, n_wr, n_rd, n_ops, seq_err, ord_err, fmt_err, hs_err, first_kind;
  int h1, h2, lat;
  bit we, pend;
  logic [27:0] resp;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic decode();
    int kind = 6;
    logic [27:0] en_v, dis_v, opc, adr;
    en_v  = (28'd4 << m_aw) | (28'd3 << (m_aw - 2));
    dis_v = 28'd4 << m_aw;
    resp  = '0;
    if (op_poll) begin
      kind = 0;
      if (op_len != 0) fmt_err++;
    end else if (op_len == 28) begin
      kind = 5;
      n_probe++;
      if (op_bits != 28'h6000000) fmt_err++;
      resp = (m_aw == 8) ? 28'hFFFFFFF : 28'hFFDFFFF;
    end else if (int'(op_len) == m_aw + 3) begin
      if (op_bits == en_v) begin
        kind = 1; we = 1;
        if (h1 != 0) seq_err++;
      end else if (op_bits == dis_v) begin
        kind = 2; we = 0;
        if (h1 != 0 || h2 != 3) seq_err++;
      end else fmt_err++;
    end else if (int'(op_len) == m_aw + 19) begin
      opc = op_bits >> (m_aw + 16);
      adr = (op_bits >> 16) & ((28'd1 << m_aw) - 1);
      if (opc == 28'd5) begin
        kind = 3;
        if (!we || h1 != 1 || h2 != 0) seq_err++;
        if (int'(adr) != n_wr || n_rd != 0) ord_err++;
        mem[adr[7:0]] = op_bits[15:0];
        n_wr++;
      end else if (opc == 28'd6 && op_bits[15:0] == 16'h0) begin
        kind = 4;
        if (!(h1 == 0 || h1 == 4)) seq_err++;
        if (n_wr != (1 << m_aw) || int'(adr) != n_rd) ord_err++;
        resp = {12'h0, mem[adr[7:0]] ^ ((int'(adr) == fault_a || int'(adr) == fault_b) ? 16'h1 : 16'h0)};
        n_rd++;
      end else fmt_err++;
    end else fmt_err++;
    if (n_ops == 0) first_kind = kind;
    n_ops++;
    h2 = h1; h1 = kind;
  endtask

  always @(negedge clk) begin
    op_done <= 1'b0;
    if (!rst_n) pend = 0;
    else begin
      if (pend) begin
        if (lat == 0) begin op_done <= 1'b1; op_rdata <= resp; pend = 0; end
        else lat = lat - 1;
      end
      if (op_req) begin
        if (pend) hs_err++;
        decode();
        pend = 1;
        lat = op_poll ? 3 : 1;
      end
    end
  end

  function automatic logic [15:0] base_word(int i, logic [47:0] s);
    if (i < 3) return s[16*i +: 16];
    if (i == 10) return 16'h40C0;
    if (i == 11 || i == 12) return 16'h0000;
    return 16'hFFFF;
  endfunction

  task automatic run(input int aw, input logic [47:0] s, input int fa, input int fb,
                     input bit restart, input bit exp_pass, input int exp_fail);
    int size = 1 << aw;
    int cyc = 0, bad = 0, ops_at_done;
    logic [15:0] acc = 0, tot = 0;
    m_aw = aw; fault_a = fa; fault_b = fb;
    n_probe = 0; n_wr = 0; n_rd = 0; n_ops = 0; seq_err = 0; ord_err = 0;
    fmt_err = 0; hs_err = 0; first_kind = -1; h1 = -1; h2 = -1; we = 0;
    for (int i = 0; i < 256; i++) mem[i] = 16'h1357 ^ 16'(i);
    sta = s;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!done, "R9 start clears done", done, 0);
    while (!done && cyc < 60000) begin
      @(negedge clk);
      cyc++;
      start = (restart && cyc == 150);
    end
    start = 1'b0;
    chk(cyc < 60000, "R8 watchdog: run did not finish", cyc, 60000);
    chk(done, "R8 done raised", done, 1);
    if (exp_pass) chk(pass, "R8 pass on clean read-back", pass, 1);
    else begin
      chk(!pass, "R7 pass low on mismatch", pass, 0);
      chk(int'(fail_addr) == exp_fail, "R7 first failing address", fail_addr, exp_fail);
      chk(n_rd == exp_fail + 1, "R7 reads stop at first mismatch", n_rd, exp_fail + 1);
    end
    chk(first_kind == 5 && n_probe == 1, "R1 single probe issued first", n_probe, 1);
    chk(n_wr == size, "R1 word count follows probed width", n_wr, size);
    chk(fmt_err == 0, "R2 frame format errors", fmt_err, 0);
    chk(seq_err == 0, "R5 per-word sequence errors", seq_err, 0);
    chk(ord_err == 0, "R6 ordering errors", ord_err, 0);
    chk(hs_err == 0, "R10 overlapping requests", hs_err, 0);
    for (int i = 0; i < size - 1; i++) begin
      if (mem[i] != base_word(i, s)) bad++;
      acc += base_word(i, s);
    end
    chk(bad == 0, "R3 image content mismatches", bad, 0);
    chk(mem[size-1] == 16'hBABA - acc, "R4 checksum word", mem[size-1], 16'hBABA - acc);
    for (int i = 0; i < size; i++) tot += mem[i];
    chk(tot == 16'hBABA, "R4 image sum", tot, 16'hBABA);
    ops_at_done = n_ops;
    repeat (40) @(negedge clk);
    chk(done && pass == exp_pass, "R9 result holds", {done, pass}, {1'b1, exp_pass});
    chk(n_ops == ops_at_done, "R10 no requests after done", n_ops, ops_at_done);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!done && !pass, "R9 reset outputs", {done, pass}, 0);
    chk(!op_req, "R10 no request in reset", op_req, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!op_req && !done, "R9 idle after reset", {op_req, done}, 0);
    run(6, 48'h0504_0302_0100, -1, -1, 0, 1, 0);
    run(8, 48'hA1B2_C3D4_E5F6, -1, -1, 0, 1, 0);
    run(6, 48'h1122_3344_5566, 5, -1, 0, 0, 5);
    run(6, 48'hFFFF_0000_8001, 40, 7, 0, 0, 7);
    run(6, 48'h0000_0000_0000, 63, -1, 0, 0, 63);
    run(8, 48'hDEAD_BEEF_0042, 200, -1, 0, 0, 200);
    run(6, 48'h0102_0304_0506, -1, -1, 1, 1, 0);
    run(8, 48'h7777_8888_9999, 0, -1, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule